// File: doc/BRIEF.md
# Serial Transmitter with Line-Break Control

This block converts bytes written by a host into asynchronous serial frames on a single output line. Bytes are queued in an eight-entry first-in first-out store and sent one at a time as a start bit, five to eight data bits (least significant first), an optional parity bit and one stop bit. Every bit lasts sixteen pulses of a baud-rate enable input, and the line rests high between frames.

Two status flags tell the host when it may write and when everything has gone out. A one-cycle command write can switch the transmitter on or off, flush it, or hold the line low as a break and later release it. The on/off bits and the command code may share one write. A switch-off requested while data is still queued does not stop traffic: the queue drains first and the transmitter then turns itself off. A break request also waits for the queue to drain, including bytes written after the request.

Top module: `serial_tx_brk`

## Requirements
- R1: After reset `txd` is 1, `tx_rdy` is 0, `tx_emt` is 0, and the transmitter is off.
- R2: A frame is a 0 start bit, then N data bits with bit 0 first, where N = 5 + `char_len` (0..3 gives 5..8; higher data bits are not sent), then a parity bit only if `par_mode` is 1 (even: the count of ones over data and parity is even) or 2 (odd), then a single stop bit of 1. Each bit lasts 16 `baud_tick` pulses.
- R3: On a cycle with `cmd_en` high, `cmd_tx_on` turns the transmitter on and `cmd_tx_off` turns it off. If both are set, the result is off. `cmd_code` 4'h3 flushes, 4'h6 requests a break and 4'h7 ends a break; any other code has no effect. Code and on/off bits act together in the same write.
- R4: Turning an idle, off transmitter on raises `tx_rdy` and `tx_emt` in the next cycle.
- R5: `tx_rdy` is 0 whenever all 8 queue entries hold data. It drops when a write fills the last free entry and rises when a byte moves into the shifter. A write made while `tx_rdy` is 0 is discarded.
- R6: While the transmitter is off, `tx_rdy` is 0 and writes are discarded; nothing is sent.
- R7: `tx_emt` rises when a stop bit ends with the queue empty, and falls on the cycle after an accepted write.
- R8: A switch-off issued while data is queued or in flight clears `tx_rdy` at once. The queued bytes are still sent, then the transmitter turns off with `tx_emt` at 0.
- R9: A break request holds `txd` at 0 only after every byte queued before or after the request has been sent. The request is ignored while the transmitter is off.
- R10: After the break-end command, `txd` is 1 on the next cycle and stays 1 for one full bit time (16 ticks) before any following start bit.
- R11: The flush command empties the queue at once, returns the shifter to idle with `txd` at 1, and clears `tx_emt`. The unsent bytes are never transmitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Enable pulse at 16 times the bit rate |
| wr_en | input | 1 | Host write strobe for one byte |
| wr_data | input | 8 | Byte to transmit |
| cmd_en | input | 1 | Command write strobe |
| cmd_code | input | 4 | Command code (flush, break on, break off) |
| cmd_tx_on | input | 1 | Turn transmitter on |
| cmd_tx_off | input | 1 | Turn transmitter off |
| char_len | input | 2 | Data bits minus five |
| par_mode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| txd | output | 1 | Serial output, idles high |
| tx_rdy | output | 1 | Queue can accept a byte |
| tx_emt | output | 1 | Transmitter has run dry |

## Verification
Two pairs of actions can meet in one cycle. In the first, a command write carries a command code and an on/off bit together. The bench provokes this with a single write that sets both on and off, which must leave `tx_rdy` and `tx_emt` low. It also uses a single write that turns an off transmitter on and requests a break; `txd` must then fall and stay low. In the second pair, host writes arrive while the shifter pulls bytes out of the queue: a burst of back-to-back writes overlaps the first pop. The scoreboard must then see exactly the nine accepted bytes, and the tenth, written while `tx_rdy` is low, must never appear on the line.

// File: rtl/stx_pkg.sv
package stx_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRK, S_MARK
  } sh_state_t;

  localparam logic [3:0] CMD_FLUSH   = 4'h3;
  localparam logic [3:0] CMD_BRK_ON  = 4'h6;
  localparam logic [3:0] CMD_BRK_OFF = 4'h7;

  localparam logic [1:0] PAR_EVEN = 2'd1;
  localparam logic [1:0] PAR_ODD  = 2'd2;
endpackage

// File: rtl/stx_fifo.sv
module stx_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rp_q, rp_d, wp_q, wp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;
  assign dout    = mem[rp_q];

  always_comb begin
    rp_d  = rp_q;
    wp_d  = wp_q;
    cnt_d = cnt_q;
    if (flush) begin
      rp_d  = '0;
      wp_d  = '0;
      cnt_d = '0;
    end else begin
      if (do_push) wp_d = step(wp_q);
      if (do_pop)  rp_d = step(rp_q);
      if (do_push && !do_pop) cnt_d = cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp_q  <= '0;
      wp_q  <= '0;
      cnt_q <= '0;
    end else begin
      rp_q  <= rp_d;
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= din;
  end
endmodule

// File: rtl/stx_shifter.sv
module stx_shifter
  import stx_pkg::*;
#(
  parameter int DW  = 8,
  parameter int TPB = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          flush,
  input  logic          q_empty,
  input  logic [DW-1:0] q_data,
  input  logic [1:0]    len_sel,
  input  logic [1:0]    par_sel,
  input  logic          brk_req,
  input  logic          brk_end,
  output logic          pop,
  output logic          txd,
  output logic          idle,
  output logic          frame_done,
  output logic          brk_start
);
  localparam int TW = $clog2(TPB);
  localparam int BW = $clog2(DW);

  sh_state_t     st_q, st_d;
  logic [TW-1:0] tc_q, tc_d;
  logic [BW-1:0] bc_q, bc_d;
  logic [DW-1:0] sr_q, sr_d;
  logic          par_q, par_d;
  logic          bit_end, par_on;
  logic [BW-1:0] last_idx;
  logic [DW-1:0] mask, mdata;

  assign bit_end  = tick && (tc_q == TW'(TPB - 1));
  assign last_idx = BW'(DW - 4) + BW'(len_sel);
  assign par_on   = (par_sel == PAR_EVEN) || (par_sel == PAR_ODD);
  assign mdata    = q_data & mask;
  assign idle     = (st_q == S_IDLE);

  always_comb begin
    for (int i = 0; i < DW; i++) mask[i] = (i <= int'(last_idx));
  end

  always_comb begin
    st_d = st_q; tc_d = tc_q; bc_d = bc_q; sr_d = sr_q; par_d = par_q;
    pop = 1'b0; frame_done = 1'b0; brk_start = 1'b0;
    if (st_q != S_IDLE && st_q != S_BRK && tick) tc_d = tc_q + 1'b1;
    if (bit_end) tc_d = '0;
    case (st_q)
      S_IDLE: begin
        if (!q_empty) begin
          pop   = 1'b1;
          sr_d  = mdata;
          par_d = (par_sel == PAR_ODD) ? ~^mdata : ^mdata;
          tc_d  = '0;
          bc_d  = '0;
          st_d  = S_START;
        end else if (brk_req) begin
          brk_start = 1'b1;
          st_d      = S_BRK;
        end
      end
      S_START: if (bit_end) st_d = S_DATA;
      S_DATA: if (bit_end) begin
        sr_d = sr_q >> 1;
        bc_d = bc_q + 1'b1;
        if (bc_q == last_idx) st_d = par_on ? S_PAR : S_STOP;
      end
      S_PAR: if (bit_end) st_d = S_STOP;
      S_STOP: if (bit_end) begin
        frame_done = 1'b1;
        st_d       = S_IDLE;
      end
      S_BRK: if (brk_end) begin
        tc_d = '0;
        st_d = S_MARK;
      end
      S_MARK: if (bit_end) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
    if (flush) begin
      st_d = S_IDLE; pop = 1'b0; frame_done = 1'b0; brk_start = 1'b0;
    end
  end

  always_comb begin
    case (st_q)
      S_START, S_BRK: txd = 1'b0;
      S_DATA:         txd = sr_q[0];
      S_PAR:          txd = par_q;
      default:        txd = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      tc_q  <= '0;
      bc_q  <= '0;
      sr_q  <= '0;
      par_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      tc_q  <= tc_d;
      bc_q  <= bc_d;
      sr_q  <= sr_d;
      par_q <= par_d;
    end
  end
endmodule

// File: rtl/serial_tx_brk.sv
module serial_tx_brk
  import stx_pkg::*;
#(
  parameter int DATA_W        = 8,
  parameter int FIFO_DEPTH    = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cmd_en,
  input  logic [3:0]        cmd_code,
  input  logic              cmd_tx_on,
  input  logic              cmd_tx_off,
  input  logic [1:0]        char_len,
  input  logic [1:0]        par_mode,
  output logic              txd,
  output logic              tx_rdy,
  output logic              tx_emt
);
  logic en_q, en_d, pend_q, pend_d, emt_q, emt_d, brk_q, brk_d;
  logic on_cmd, off_cmd, flush_cmd, brk_cmd, stp_cmd;
  logic push, pop, q_full, q_empty;
  logic sh_idle, frame_done, brk_start, drain_done, idle_after;
  logic [DATA_W-1:0] q_data;

  assign on_cmd    = cmd_en && cmd_tx_on && !cmd_tx_off;
  assign off_cmd   = cmd_en && cmd_tx_off;
  assign flush_cmd = cmd_en && (cmd_code == CMD_FLUSH);
  assign brk_cmd   = cmd_en && (cmd_code == CMD_BRK_ON);
  assign stp_cmd   = cmd_en && (cmd_code == CMD_BRK_OFF);

  assign tx_rdy     = en_q && !pend_q && !q_full;
  assign tx_emt     = emt_q;
  assign push       = wr_en && tx_rdy;
  assign drain_done = pend_q && sh_idle && q_empty && !brk_q;
  assign idle_after = (sh_idle || flush_cmd) && (q_empty || flush_cmd);

  stx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(flush_cmd), .push(push), .pop(pop),
    .din(wr_data), .dout(q_data), .full(q_full), .empty(q_empty)
  );

  stx_shifter #(.DW(DATA_W), .TPB(TICKS_PER_BIT)) u_shift (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .flush(flush_cmd),
    .q_empty(q_empty), .q_data(q_data), .len_sel(char_len), .par_sel(par_mode),
    .brk_req(brk_q), .brk_end(stp_cmd), .pop(pop), .txd(txd), .idle(sh_idle),
    .frame_done(frame_done), .brk_start(brk_start)
  );

  always_comb begin
    en_d = en_q; pend_d = pend_q; emt_d = emt_q; brk_d = brk_q;
    if (frame_done && q_empty && !pend_q) emt_d = 1'b1;
    if (push) emt_d = 1'b0;
    if (drain_done) begin
      en_d = 1'b0; pend_d = 1'b0; emt_d = 1'b0;
    end
    if (brk_start || stp_cmd) brk_d = 1'b0;
    if (flush_cmd) begin
      emt_d = 1'b0; brk_d = 1'b0;
    end
    if (off_cmd) begin
      if (en_q) begin
        if (idle_after && !(brk_q && !flush_cmd)) begin
          en_d = 1'b0; pend_d = 1'b0; emt_d = 1'b0; brk_d = 1'b0;
        end else begin
          pend_d = 1'b1;
        end
      end
    end else if (on_cmd && (!en_q || pend_q)) begin
      en_d   = 1'b1;
      pend_d = 1'b0;
      emt_d  = idle_after;
    end
    if (brk_cmd && en_d) brk_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      emt_q  <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      en_q   <= en_d;
      pend_q <= pend_d;
      emt_q  <= emt_d;
      brk_q  <= brk_d;
    end
  end
endmodule

module serial_tx_brk_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_en,
  input logic [3:0] cmd_code,
  input logic       cmd_tx_on,
  input logic       cmd_tx_off,
  input logic       wr_en,
  input logic       txd,
  input logic       tx_rdy,
  input logic       tx_emt,
  input logic       q_full,
  input logic       q_empty,
  input logic       en_q,
  input logic       brk_q
);
  assert_full_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    q_full |-> !tx_rdy);

  assert_off_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !tx_rdy);

  assert_off_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_tx_on && cmd_tx_off) |=> !tx_rdy);

  assert_emt_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_emt |-> q_empty);

  assert_load_clears_emt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tx_rdy) |=> !tx_emt);

  assert_flush_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && cmd_code == 4'h3) |=> (q_empty && txd && !tx_emt));

  assert_break_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_q && !q_empty && !cmd_en) |=> brk_q);
endmodule

bind serial_tx_brk serial_tx_brk_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_code(cmd_code),
  .cmd_tx_on(cmd_tx_on), .cmd_tx_off(cmd_tx_off), .wr_en(wr_en), .txd(txd),
  .tx_rdy(tx_rdy), .tx_emt(tx_emt), .q_full(q_full), .q_empty(q_empty),
  .en_q(en_q), .brk_q(brk_q)
);

// File: tb/serial_tx_brk_tb.sv
module serial_tx_brk_tb;
  logic clk, rst_n, baud_tick, wr_en, cmd_en, cmd_tx_on, cmd_tx_off;
  logic [7:0] wr_data;
  logic [3:0] cmd_code;
  logic [1:0] char_len, par_mode, tdiv;
  logic txd, tx_rdy, tx_emt;

  typedef struct {logic [7:0] d; int nb; logic [1:0] pm;} item_t;
  item_t expq[$];
  int checks, fails;
  bit mon_busy, allow_low, abort, done, prev_txd;

  serial_tx_brk u_dut (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en),
    .wr_data(wr_data), .cmd_en(cmd_en), .cmd_code(cmd_code),
    .cmd_tx_on(cmd_tx_on), .cmd_tx_off(cmd_tx_off), .char_len(char_len),
    .par_mode(par_mode), .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin tdiv = '0; baud_tick = 1'b0; end
  always @(negedge clk) begin
    tdiv      <= tdiv + 2'd1;
    baud_tick <= (tdiv == 2'd3);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic send(input logic [7:0] d, input bit expect_it);
    item_t it;
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    if (expect_it) begin
      it.nb = 5 + int'(char_len); it.pm = par_mode;
      it.d = d & 8'((1 << it.nb) - 1);
      expq.push_back(it);
    end
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cmd(input logic [3:0] c, input logic on, input logic off);
    @(negedge clk);
    cmd_en = 1'b1; cmd_code = c; cmd_tx_on = on; cmd_tx_off = off;
    @(negedge clk);
    cmd_en = 1'b0; cmd_code = '0; cmd_tx_on = 1'b0; cmd_tx_off = 1'b0;
  endtask

  task automatic wait_idle();
    while (expq.size() != 0 || mon_busy) @(negedge clk);
    repeat (100) @(negedge clk);
  endtask

  task automatic hold_level(input int n, input logic lvl, input string tag);
    bit ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (txd !== lvl) ok = 1'b0;
    end
    chk(ok, tag, {31'd0, ~lvl}, {31'd0, lvl});
  endtask

  // Scoreboard monitor: decodes frames on txd and compares with the queue
  initial begin
    item_t it;
    logic [7:0] got;
    logic st_b, pb, sp, pexp;
    prev_txd = 1'b1; mon_busy = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && prev_txd && !txd) begin
        if (expq.size() == 0) begin
          if (!allow_low) chk(1'b0, "R5 R6 frame seen with nothing expected", 32'd1, 32'd0);
          while (!txd) @(negedge clk);
        end else begin
          mon_busy = 1'b1;
          it = expq.pop_front();
          got = '0; pb = 1'b0; pexp = 1'b0;
          repeat (31) @(negedge clk);
          st_b = txd;
          for (int i = 0; i < it.nb; i++) begin
            repeat (64) @(negedge clk);
            got[i] = txd;
          end
          if (it.pm == 2'd1 || it.pm == 2'd2) begin
            repeat (64) @(negedge clk);
            pb = txd;
            pexp = (it.pm == 2'd2) ? ~^it.d : ^it.d;
          end
          repeat (64) @(negedge clk);
          sp = txd;
          if (abort) abort = 1'b0;
          else chk(st_b == 1'b0 && got == it.d && pb == pexp && sp == 1'b1,
                   "R2 frame contents", {21'd0, st_b, got, pb, sp}, {21'd0, 1'b0, it.d, pexp, 1'b1});
          mon_busy = 1'b0;
        end
      end
      prev_txd = txd;
    end
  end

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    int n;
    checks = 0; fails = 0; allow_low = 1'b0; abort = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; cmd_en = 1'b0; cmd_code = '0;
    cmd_tx_on = 1'b0; cmd_tx_off = 1'b0; char_len = 2'd3; par_mode = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(txd == 1'b1 && tx_rdy == 1'b0 && tx_emt == 1'b0, "R1 reset state",
        {29'd0, txd, tx_rdy, tx_emt}, 32'h4);

    // R6: write while off is dropped
    send(8'h55, 1'b0);
    hold_level(300, 1'b1, "R6 write while off not sent");

    // R4: enable from idle
    cmd(4'h0, 1'b1, 1'b0);
    chk(tx_rdy && tx_emt, "R4 enable raises flags", {30'd0, tx_rdy, tx_emt}, 32'h3);

    // R2 / R7: several formats
    send(8'hA5, 1'b1);
    chk(tx_emt == 1'b0, "R7 load clears emt", {31'd0, tx_emt}, 32'd0);
    send(8'h3C, 1'b1);
    wait_idle();
    chk(tx_emt && tx_rdy, "R7 emt after last stop", {30'd0, tx_rdy, tx_emt}, 32'h3);
    char_len = 2'd0; par_mode = 2'd1;
    send(8'hF3, 1'b1); send(8'h06, 1'b1);
    wait_idle();
    char_len = 2'd2; par_mode = 2'd2;
    send(8'h7F, 1'b1); send(8'h40, 1'b1);
    wait_idle();
    char_len = 2'd1; par_mode = 2'd1;
    send(8'h2A, 1'b1);
    wait_idle();
    char_len = 2'd3; par_mode = 2'd0;

    // R5: burst of 10 writes, the 10th meets a full queue
    for (int i = 0; i < 9; i++) begin
      item_t it;
      @(negedge clk);
      wr_en = 1'b1; wr_data = 8'(8'h10 + i);
      it.d = 8'(8'h10 + i); it.nb = 8; it.pm = 2'd0;
      expq.push_back(it);
    end
    @(negedge clk);
    chk(tx_rdy == 1'b0, "R5 ready low when full", {31'd0, tx_rdy}, 32'd0);
    wr_data = 8'hEE;
    @(negedge clk);
    wr_en = 1'b0;
    wait_idle();
    chk(tx_rdy == 1'b1, "R5 ready back after drain", {31'd0, tx_rdy}, 32'd1);

    // R3: on and off in one write gives off
    cmd(4'h0, 1'b1, 1'b1);
    chk(!tx_rdy && !tx_emt, "R3 off wins over on", {30'd0, tx_rdy, tx_emt}, 32'd0);
    send(8'h11, 1'b0);
    hold_level(300, 1'b1, "R3 R6 nothing sent after both bits");

    // R8: pending switch-off
    cmd(4'h0, 1'b1, 1'b0);
    send(8'h81, 1'b1); send(8'h82, 1'b1); send(8'h83, 1'b1);
    cmd(4'h0, 1'b0, 1'b1);
    chk(tx_rdy == 1'b0, "R8 ready clears at once", {31'd0, tx_rdy}, 32'd0);
    wait_idle();
    chk(!tx_emt && !tx_rdy, "R8 off after drain", {30'd0, tx_rdy, tx_emt}, 32'd0);
    send(8'h77, 1'b0);
    hold_level(300, 1'b1, "R8 R6 writes dropped after drain");

    // R9: break waits for queue, including later loads
    cmd(4'h0, 1'b1, 1'b0);
    send(8'hC1, 1'b1); send(8'hC2, 1'b1);
    cmd(4'h6, 1'b0, 1'b0);
    send(8'hC3, 1'b1);
    allow_low = 1'b1;
    wait_idle();
    hold_level(200, 1'b0, "R9 break held after queue");

    // R10: stop break, one mark bit before next start
    allow_low = 1'b0;
    cmd(4'h7, 1'b0, 1'b0);
    chk(txd == 1'b1, "R10 line high after break end", {31'd0, txd}, 32'd1);
    send(8'h96, 1'b1);
    n = 2;
    while (txd && n < 200) begin @(negedge clk); n++; end
    chk(n >= 60 && n <= 70, "R10 mark gap length", n, 32'd64);
    wait_idle();

    // R9: break ignored while off; R3: enable and break in one write
    cmd(4'h0, 1'b0, 1'b1);
    cmd(4'h6, 1'b0, 1'b0);
    cmd(4'h0, 1'b1, 1'b0);
    hold_level(300, 1'b1, "R9 break ignored while off");
    cmd(4'h0, 1'b0, 1'b1);
    allow_low = 1'b1;
    cmd(4'h6, 1'b1, 1'b0);
    repeat (20) @(negedge clk);
    hold_level(100, 1'b0, "R3 R9 enable and break in one write");
    cmd(4'h7, 1'b0, 1'b0);
    allow_low = 1'b0;
    repeat (100) @(negedge clk);
    chk(txd == 1'b1, "R10 line high after second break", {31'd0, txd}, 32'd1);

    // R11: flush mid-frame
    send(8'h31, 1'b1); send(8'h32, 1'b1); send(8'h33, 1'b1);
    repeat (200) @(negedge clk);
    abort = 1'b1;
    cmd(4'h3, 1'b0, 1'b0);
    expq.delete();
    chk(txd && !tx_emt && tx_rdy, "R11 flush state", {29'd0, txd, tx_rdy, tx_emt}, 32'h6);
    hold_level(900, 1'b1, "R11 discarded bytes not sent");
    send(8'h5A, 1'b1);
    wait_idle();
    chk(tx_emt == 1'b1, "R11 R7 resumes after flush", {31'd0, tx_emt}, 32'd1);

    done = 1'b1;
    summary();
  end
endmodule